// File: doc/BRIEF.md
# Maskable Interrupt Aggregator with Reassert Pulse

This block gathers four sticky internal interrupt flags into one active-low interrupt line. The flags come from the event, general-purpose input, logic and overflow sources. Each flag is set by a one-cycle strobe from its source and cleared by a write-1 request from the register interface. Each flag has an enable bit. An enable decides whether that flag may pull the interrupt line low. It never stops the flag from recording its source.

A mode input selects how the line behaves when software clears one of several pending interrupts. In hold mode the line simply stays low while any enabled flag is pending. In pulse mode, clearing one enabled flag while another enabled flag stays pending releases the line for a fixed number of microsecond ticks (50 by default), after which it goes low again. A level-sensitive host therefore sees a fresh falling edge for the interrupts still outstanding. The line is driven from a register, so it never glitches.

Top module: `irq_pulse_merge`

## Requirements
- R1: After reset all flags read 0 and `irq_n_o` is 1.
- R2: A 1 on `set_i[k]` makes `flags_o[k]` read 1 after the next clock edge, and the flag stays 1 until it is cleared. Bit order: 0 event, 1 general-purpose input, 2 logic, 3 overflow.
- R3: A 1 on `clr_i[k]` clears `flags_o[k]` at the next edge. When `set_i[k]` and `clr_i[k]` are both 1 in the same cycle, the flag ends up 1 and no release window starts.
- R4: `irq_n_o` is a register. One edge after the flags and enables change, it is 0 when some k has `flags_o[k] & en_i[k]` set and no release window is running, and 1 otherwise.
- R5: A flag whose enable is 0 still latches and reads back, but it has no effect on `irq_n_o`. Clearing it never starts a release window.
- R6: With `pulse_mode_i` = 0, clearing some enabled pending flags while another enabled flag stays pending leaves `irq_n_o` at 0.
- R7: With `pulse_mode_i` = 1, a clear that removes an enabled pending flag while at least one enabled flag remains pending starts a window. The window begins at the edge that takes the clear, and `irq_n_o` is 1 from the following edge onwards. After GAP_US edges that have `us_tick_i` = 1, `irq_n_o` returns to 0 at the next edge.
- R8: If no enabled flag is pending when a window ends, `irq_n_o` stays 1.
- R9: A new qualifying clear during a running window restarts the full GAP_US tick count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_i | input | N_SRC | Per-source set strobes |
| clr_i | input | N_SRC | Per-source write-1-to-clear requests |
| en_i | input | N_SRC | Per-source interrupt enables |
| pulse_mode_i | input | 1 | 0: hold low, 1: release-and-reassert on partial clear |
| us_tick_i | input | 1 | One-cycle pulse every microsecond |
| flags_o | output | N_SRC | Flag status |
| irq_n_o | output | 1 | Active-low interrupt line |

## Verification
The bench builds the block with four sources and GAP_US = 4. The window is counted with ticks that the bench places itself, so both edges of the window can be hit exactly. With this configuration the bench can sweep every combination of pending pattern, enable mask and clear mask in both modes, which is 8192 cases. In each case it compares the line against a value computed from the masks, so every case that should start a window, and every case that should not, is visited.

// File: rtl/irq_pkg.sv
// Shared definitions for the interrupt aggregator: source bit positions
// and the output mode encoding. Assumes four sources in the order below.
package irq_pkg;
    localparam int SRC_EVENT = 0;
    localparam int SRC_GPI   = 1;
    localparam int SRC_LOGIC = 2;
    localparam int SRC_OVFL  = 3;

    typedef enum logic {
        MODE_HOLD  = 1'b0,
        MODE_PULSE = 1'b1
    } irq_mode_e;
endpackage

// File: rtl/irq_flag_bank.sv
// Sticky flag register bank. Each bit is set by its strobe and cleared by
// its write-1 request, and set wins a tie. Also exposes the next-state
// value so that the parent can judge a clear before it lands.
// Assumes one-cycle strobes that are synchronous to clk.
module irq_flag_bank #(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] flags_o,
    output logic [N_SRC-1:0] flags_nxt_o
);
    logic [N_SRC-1:0] flags_q;

    // Next state: clear first, then set, so that set has priority.
    always_comb flags_nxt_o = (flags_q & ~clr_i) | set_i;

    // Flag storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_nxt_o;
    end

    assign flags_o = flags_q;

    p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)));
    p_clear_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((flags_q & $past(clr_i & ~set_i)) == '0));
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(flags_q));
endmodule

// File: rtl/irq_gap_timer.sv
// Release-window timer. A start loads GAP_US, and each tick counts down
// until zero. A start has priority over a tick, so a new start restarts
// the window. Assumes tick_i is a one-cycle pulse.
module irq_gap_timer #(
    parameter int GAP_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tick_i,
    output logic busy_o
);
    localparam int CW = $clog2(GAP_US + 1);
    localparam logic [CW-1:0] GAP_LD = CW'(GAP_US);

    logic [CW-1:0] cnt_q;

    // Load on start, count down on ticks while non-zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (start_i)               cnt_q <= GAP_LD;
        else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

    p_start_loads_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt_q == GAP_LD));
    p_no_tick_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !tick_i) |=> $stable(cnt_q));
    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= GAP_LD);
endmodule

// File: rtl/irq_pulse_merge.sv
// Top of the interrupt aggregator. Masks the sticky flags with their
// enables and detects, in pulse mode, a clear that leaves other enabled
// flags pending. It runs the release timer and registers the active-low
// line. Assumes the inputs are synchronous to clk.
module irq_pulse_merge #(
    parameter int N_SRC  = 4,
    parameter int GAP_US = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_i,
    input  logic [N_SRC-1:0] clr_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic             pulse_mode_i,
    input  logic             us_tick_i,
    output logic [N_SRC-1:0] flags_o,
    output logic             irq_n_o
);
    import irq_pkg::*;

    logic [N_SRC-1:0] flags;
    logic [N_SRC-1:0] flags_nxt;
    logic [N_SRC-1:0] dropped;
    logic             any_pend;
    logic             still_pend;
    logic             restart;
    logic             busy;
    logic             irq_n_q;
    irq_mode_e        mode;

    irq_flag_bank #(.N_SRC(N_SRC)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (set_i),
        .clr_i       (clr_i),
        .flags_o     (flags),
        .flags_nxt_o (flags_nxt)
    );

    // Decode the mode and find enabled flags that this clear removes.
    always_comb begin
        mode       = irq_mode_e'(pulse_mode_i);
        dropped    = flags & en_i & clr_i & ~set_i;
        any_pend   = |(flags & en_i);
        still_pend = |(flags_nxt & en_i);
        restart    = (mode == MODE_PULSE) && (|dropped) && still_pend;
    end

    irq_gap_timer #(.GAP_US(GAP_US)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (restart),
        .tick_i  (us_tick_i),
        .busy_o  (busy)
    );

    // Glitch-free output register: low only when pending and not released.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n_q <= 1'b1;
        else        irq_n_q <= ~(any_pend & ~busy);
    end

    assign flags_o = flags;
    assign irq_n_o = irq_n_q;

    p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & en_i) == '0) |=> irq_n_o);
    p_window_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> ##1 irq_n_o);
    p_hold_mode_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |-> !restart);
    p_disabled_no_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dropped == '0) |-> !restart);
endmodule

// File: tb/irq_pulse_merge_bench.sv
module irq_pulse_merge_bench;
    localparam int N = 4;
    localparam int G = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] set_i = '0, clr_i = '0, en_i = '0;
    logic         pulse_mode_i = 1'b0, us_tick_i = 1'b0;
    logic [N-1:0] flags_o;
    logic         irq_n_o;
    int           n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    irq_pulse_merge #(.N_SRC(N), .GAP_US(G)) u_irq_pulse_merge (
        .clk(clk), .rst_n(rst_n), .set_i(set_i), .clr_i(clr_i), .en_i(en_i),
        .pulse_mode_i(pulse_mode_i), .us_tick_i(us_tick_i),
        .flags_o(flags_o), .irq_n_o(irq_n_o));

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        us_tick_i = 1'b1; step(n); us_tick_i = 1'b0;
    endtask

    task automatic load(input logic [N-1:0] p);
        clr_i = '1; us_tick_i = 1'b1; step(2);
        clr_i = '0; us_tick_i = 1'b0;
        set_i = p; step(1); set_i = '0; step(1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(3);
        chk(8'(flags_o), 8'h0, "R1 flags after reset");
        chk(8'(irq_n_o), 8'h1, "R1 line after reset");
        rst_n = 1'b1;
        step(1);

        // R2/R4/R5 sweep: every pattern under every enable mask.
        for (int p = 0; p < 16; p++) begin
            for (int e = 0; e < 16; e++) begin
                en_i = 4'(e);
                load(4'(p));
                chk(8'(flags_o), 8'(p), "R2 flag latch");
                chk(8'(irq_n_o), 8'(((p & e) == 0) ? 1 : 0),
                    ((p & e) == 0 && p != 0) ? "R5 disabled no effect" : "R4 line level");
            end
        end

        // R6/R7/R8 sweep over mode, pattern, enables and clear mask.
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 16; p++) begin
                for (int e = 0; e < 16; e++) begin
                    for (int c = 0; c < 16; c++) begin
                        logic rem, trig;
                        pulse_mode_i = m[0];
                        en_i = 4'(e);
                        load(4'(p));
                        clr_i = 4'(c); step(1); clr_i = '0;
                        rem  = ((p & ~c & e) & 15) != 0;
                        trig = (m == 1) && ((p & e & c) != 0) && rem;
                        step(1);
                        chk(8'(flags_o), 8'(p & ~c & 15), "R3 clear lands");
                        if (trig) begin
                            chk(8'(irq_n_o), 8'h1, "R7 window opens");
                            ticks(G - 1); step(1);
                            chk(8'(irq_n_o), 8'h1, "R7 window held");
                            ticks(1); step(1);
                            chk(8'(irq_n_o), 8'h0, "R7 reasserted");
                        end else begin
                            chk(8'(irq_n_o), 8'(rem ? 0 : 1),
                                (m == 0 && rem) ? "R6 hold mode stays low" : "R8 no pending stays high");
                        end
                    end
                end
            end
        end

        // R3: set and clear on the same bit in pulse mode.
        pulse_mode_i = 1'b1; en_i = '1;
        load(4'b0011);
        set_i = 4'b0001; clr_i = 4'b0001; step(1); set_i = '0; clr_i = '0;
        step(1);
        chk(8'(flags_o), 8'h03, "R3 set wins");
        chk(8'(irq_n_o), 8'h0, "R3 set wins no window");

        // R8: window runs out after all flags are cleared.
        load(4'b0111);
        clr_i = 4'b0001; step(1); clr_i = '0; step(1);
        chk(8'(irq_n_o), 8'h1, "R7 window opens");
        clr_i = 4'b0110; step(1); clr_i = '0;
        ticks(G + 1); step(1);
        chk(8'(irq_n_o), 8'h1, "R8 stays high after window");

        // R9: a second qualifying clear restarts the count.
        load(4'b0111);
        clr_i = 4'b0001; step(1); clr_i = '0;
        ticks(G - 1);
        clr_i = 4'b0010; step(1); clr_i = '0;
        ticks(G - 1); step(1);
        chk(8'(irq_n_o), 8'h1, "R9 restarted window held");
        ticks(1); step(1);
        chk(8'(irq_n_o), 8'h0, "R9 reasserted after restart");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule